// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial memory front end and gathers the data bytes of one write transaction into a page-sized staging buffer. The front end reports four things: the start of a write with its start address, each complete data byte, the number of bits already received of a byte that is not yet complete, and the moment chip select is released. For every incoming byte the block presents the target address on a query port. An external protection policy answers with a grant, and the block stores that grant as a per-byte valid flag.

When chip select is released exactly on a byte boundary, the write latch is set and at least one byte has arrived, the block starts a programming interval. The interval lasts a fixed, parameterised number of clock cycles and drives a busy flag. During the interval the granted bytes are copied from the buffer into a behavioural byte array. At the end the block pulses a request that clears the external write latch. While busy, the block ignores new writes, new bytes, chip select releases and array reads. The array has a registered read port for the front end. `WC_CYCLES` must be at least the page size.

Top module: `page_commit_buf`

## Requirements
- R1: After reset `busy_o` and `wel_clr_o` are 0, `rd_data_o` is 0, `grant_addr_o` is 0, and every array byte reads as 0.
- R2: `grant_addr_o` equals the page bits of the start address joined to a 6-bit in-page offset. The offset starts at the start address's low bits and increments by one after each accepted byte. The page bits never change during a transaction.
- R3: When more than 64 bytes are sent, the offset wraps to 0 within the same page, and a later byte replaces the earlier byte at the same offset.
- R4: A chip select release (`cs_rise_i`) starts programming only if `bit_cnt_i` is 0, a write is in progress and at least one byte was accepted. Otherwise `busy_o` stays 0, the array is unchanged and the transaction is dropped.
- R5: A chip select release while `wel_i` is 0 starts no programming and leaves the array unchanged.
- R6: A qualifying release raises `busy_o` on the next clock edge. `busy_o` then stays high for exactly `WC_CYCLES` cycles.
- R7: `wel_clr_o` is high for exactly the one cycle in which `busy_o` has just fallen, and at no other time.
- R8: A byte accepted with `grant_i` at 0 is not written to the array.
- R9: Only offsets that received a byte are written. All other bytes of the page keep their old contents.
- R10: While `busy_o` is 1, `wr_start_i`, `byte_valid_i`, `cs_rise_i` and `rd_en_i` have no effect, and `rd_data_o` holds its value.
- R11: When not busy, `rd_en_i` loads `rd_data_o` with the array byte at `rd_addr_i` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Begin a write transaction at `addr_i` |
| addr_i | input | ADDR_W | Start byte address |
| byte_valid_i | input | 1 | A complete data byte is present |
| byte_i | input | DATA_W | Data byte |
| bit_cnt_i | input | BIT_W | Bits received of the current, unfinished byte |
| cs_rise_i | input | 1 | Chip select released |
| wel_i | input | 1 | Write-enable latch state |
| grant_i | input | 1 | Protection grant for `grant_addr_o` |
| grant_addr_o | output | ADDR_W | Address of the next byte to be accepted |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Registered read data |
| busy_o | output | 1 | Programming interval in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write latch |

## Verification
The bench compares `busy_o`, `wel_clr_o` and `grant_addr_o` with a reference model on every cycle.

- A wrong in-page offset or a drifting page field shows on `grant_addr_o` on the cycle after the byte that caused it.
- A miscounted timer moves the falling edge of `busy_o` or the `wel_clr_o` pulse, and this is caught on that same cycle.
- A wrong valid flag, buffer slot or wrap shows only after programming ends, when array reads return bytes that should not be there. Read-back therefore covers the bytes next to each written range and the bytes at its wrap point.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;

  function automatic logic commit_ok(input logic filling, input logic got,
                                     input logic wel, input logic aligned);
    return filling && got && wel && aligned;
  endfunction
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6,
  parameter int BIT_W  = 3,
  localparam int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                byte_valid_i,
  input  logic                cs_rise_i,
  input  logic [BIT_W-1:0]    bit_cnt_i,
  input  logic                wel_i,
  input  logic                prog_done_i,
  output logic                busy_o,
  output logic [PG_IDX_W-1:0] page_o,
  output logic [PAGE_W-1:0]   ptr_o,
  output logic                cap_o,
  output logic                clr_o,
  output logic                prog_start_o,
  output logic                wel_clr_o
);
  pwb_state_e          state_q, state_d;
  logic [PG_IDX_W-1:0] page_q;
  logic [PAGE_W-1:0]   ptr_q;
  logic                got_q, wclr_q;
  logic                idle_ok;

  assign idle_ok      = (state_q != ST_PROG);
  assign clr_o        = idle_ok && wr_start_i;
  assign cap_o        = (state_q == ST_FILL) && byte_valid_i && !wr_start_i;
  assign prog_start_o = idle_ok && cs_rise_i &&
                        commit_ok(state_q == ST_FILL, got_q, wel_i, bit_cnt_i == '0);

  always_comb begin
    state_d = state_q;
    if (state_q == ST_PROG) begin
      if (prog_done_i) state_d = ST_IDLE;
    end else if (prog_start_o) begin
      state_d = ST_PROG;
    end else if (wr_start_i) begin
      state_d = ST_FILL;
    end else if (cs_rise_i) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      got_q   <= 1'b0;
      wclr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wclr_q  <= (state_q == ST_PROG) && prog_done_i;
      if (clr_o) begin
        page_q <= addr_i[ADDR_W-1:PAGE_W];
        ptr_q  <= addr_i[PAGE_W-1:0];
        got_q  <= 1'b0;
      end else if (cap_o) begin
        ptr_q <= ptr_q + 1'b1;  // wraps inside the page
        got_q <= 1'b1;
      end
    end
  end

  assign busy_o    = (state_q == ST_PROG);
  assign page_o    = page_q;
  assign ptr_o     = ptr_q;
  assign wel_clr_o = wclr_q;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int WC_CYCLES = 96,
  parameter int PAGE_W    = 6,
  localparam int CW0   = $clog2(WC_CYCLES + 1),
  localparam int CNT_W = (CW0 > PAGE_W + 1) ? CW0 : PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              slot_live_o,
  output logic [PAGE_W-1:0] slot_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done_o      = run_q && (cnt_q == CNT_W'(WC_CYCLES - 1));
  assign slot_live_o = run_q && (cnt_q < CNT_W'(1 << PAGE_W));
  assign slot_o      = cnt_q[PAGE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_buf.sv
module pwb_buf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8,
  localparam int SLOTS = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_ok_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_idx_i == PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        data_q[g] <= wr_data_i;
        vld_q[g]  <= wr_ok_i;  // latest byte decides
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (re_i) rd_q <= mem_q[ra_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WC_CYCLES = 96,
  localparam int BIT_W    = $clog2(DATA_W),
  localparam int PG_IDX_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic              cs_rise_i,
  input  logic              wel_i,
  input  logic              grant_i,
  output logic [ADDR_W-1:0] grant_addr_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  logic [PG_IDX_W-1:0] page;
  logic [PAGE_W-1:0]   ptr, slot;
  logic                cap, clr, prog_start, prog_done, slot_live;
  logic [DATA_W-1:0]   slot_data;
  logic                slot_vld;

  pwb_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BIT_W(BIT_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_start_i, .addr_i, .byte_valid_i, .cs_rise_i,
    .bit_cnt_i, .wel_i,
    .prog_done_i (prog_done),
    .busy_o,
    .page_o      (page),
    .ptr_o       (ptr),
    .cap_o       (cap),
    .clr_o       (clr),
    .prog_start_o(prog_start),
    .wel_clr_o
  );

  pwb_timer #(.WC_CYCLES(WC_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i    (prog_start),
    .done_o     (prog_done),
    .slot_live_o(slot_live),
    .slot_o     (slot)
  );

  pwb_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .wr_i     (cap),
    .wr_idx_i (ptr),
    .wr_data_i(byte_i),
    .wr_ok_i  (grant_i),
    .rd_idx_i (slot),
    .rd_data_o(slot_data),
    .rd_vld_o (slot_vld)
  );

  pwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .we_i(slot_live && slot_vld),
    .wa_i({page, slot}),
    .wd_i(slot_data),
    .re_i(rd_en_i && !busy_o),
    .ra_i(rd_addr_i),
    .rd_o(rd_data_o)
  );

  assign grant_addr_o = {page, ptr};
endmodule

// File: rtl/page_commit_buf_chk.sv
module page_commit_buf_chk #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int BIT_W     = 3,
  parameter int WC_CYCLES = 96,
  localparam int CW0   = $clog2(WC_CYCLES + 1),
  localparam int CNT_W = (CW0 > 2) ? CW0 : 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_start_i,
  input logic              byte_valid_i,
  input logic              cs_rise_i,
  input logic [BIT_W-1:0]  bit_cnt_i,
  input logic              wel_i,
  input logic [ADDR_W-1:0] grant_addr_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              wel_clr_o
);
  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  a_r2_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !wr_start_i |=>
      grant_addr_o[ADDR_W-1:PAGE_W] == $past(grant_addr_o[ADDR_W-1:PAGE_W]));

  a_r4_midbyte_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cs_rise_i && (bit_cnt_i != '0) |=> !busy_o);

  a_r5_no_wel_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cs_rise_i && !wel_i |=> !busy_o);

  a_r6_not_too_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_len < CNT_W'(WC_CYCLES));

  a_r6_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(run_len) == CNT_W'(WC_CYCLES - 1));

  a_r7_pulse_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> wel_clr_o);

  a_r7_pulse_only_then: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> !busy_o && $past(busy_o));

  a_r10_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_data_o));
endmodule

bind page_commit_buf page_commit_buf_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BIT_W(BIT_W),
  .WC_CYCLES(WC_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_start_i(wr_start_i),
  .byte_valid_i(byte_valid_i), .cs_rise_i(cs_rise_i), .bit_cnt_i(bit_cnt_i),
  .wel_i(wel_i), .grant_addr_o(grant_addr_o), .rd_data_o(rd_data_o),
  .busy_o(busy_o), .wel_clr_o(wel_clr_o)
);

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;
  localparam int AW = 9, PW = 6, DW = 8, BW = 3, WC = 96;
  localparam int PG = 1 << PW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_start = 0, byte_valid = 0, cs_rise = 0, wel = 0, grant = 0, rd_en = 0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [DW-1:0] byte_d = '0;
  logic [BW-1:0] bit_cnt = '0;
  logic [AW-1:0] grant_addr_o;
  logic [DW-1:0] rd_data_o;
  logic          busy_o, wel_clr_o;

  page_commit_buf #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .WC_CYCLES(WC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .addr_i(addr),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .bit_cnt_i(bit_cnt),
    .cs_rise_i(cs_rise), .wel_i(wel), .grant_i(grant), .grant_addr_o(grant_addr_o),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .wel_clr_o(wel_clr_o)
  );

  int  n_cmp = 0, n_bad = 0;
  bit  finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit            m_busy, m_wclr, m_act, m_got;
  int            m_cnt, m_page, m_ptr;
  logic [DW-1:0] m_buf [PG];
  bit            m_vld [PG];
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wclr = 0; m_act = 0; m_got = 0;
      m_cnt = 0; m_page = 0; m_ptr = 0; m_rd = '0;
      for (int i = 0; i < PG; i++) begin m_buf[i] = '0; m_vld[i] = 0; end
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    end else begin
      m_wclr = 0;
      if (m_busy) begin
        if (m_cnt < PG && m_vld[m_cnt]) m_mem[m_page * PG + m_cnt] = m_buf[m_cnt];
        if (m_cnt == WC - 1) begin m_busy = 0; m_wclr = 1; end
        m_cnt++;
      end else begin
        if (rd_en) m_rd = m_mem[rd_addr];
        if (wr_start) begin
          m_page = int'(addr) / PG; m_ptr = int'(addr) % PG; m_got = 0; m_act = 1;
          for (int i = 0; i < PG; i++) m_vld[i] = 0;
        end else if (byte_valid && m_act) begin
          m_buf[m_ptr] = byte_d; m_vld[m_ptr] = grant; m_got = 1;
          m_ptr = (m_ptr + 1) % PG;
        end
        if (cs_rise) begin
          if (m_act && m_got && wel && bit_cnt == 0) begin m_busy = 1; m_cnt = 0; end
          m_act = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6 busy_o", 32'(busy_o), 32'(m_busy));
      check("R7 wel_clr_o", 32'(wel_clr_o), 32'(m_wclr));
      check("R2 grant_addr_o", 32'(grant_addr_o), 32'(m_page * PG + m_ptr));
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic start(input int a);
    wr_start = 1; addr = AW'(a); tick(); wr_start = 0;
  endtask
  task automatic send(input int d, input bit g);
    byte_valid = 1; byte_d = DW'(d); grant = g; tick(); byte_valid = 0;
  endtask
  task automatic csr(input int b);
    cs_rise = 1; bit_cnt = BW'(b); tick(); cs_rise = 0; bit_cnt = '0;
  endtask
  task automatic wait_idle();
    while (busy_o) tick();
  endtask
  task automatic rd(input int a, input int exp, input string req);
    rd_en = 1; rd_addr = AW'(a); tick(); rd_en = 0;
    check(req, 32'(rd_data_o), 32'(exp));
    check({req, " model"}, 32'(rd_data_o), 32'(m_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 busy", 32'(busy_o), 0);
    check("R1 wel_clr", 32'(wel_clr_o), 0);
    check("R1 rd_data", 32'(rd_data_o), 0);
    check("R1 grant_addr", 32'(grant_addr_o), 0);
    rd(5, 0, "R1 array");

    // R9 / R6: short write mid-page, count busy cycles
    wel = 1;
    start(2 * PG + 10);
    for (int i = 0; i < 5; i++) send(8'hA0 + i, 1);
    csr(0);
    c = 0;
    while (busy_o) begin c++; tick(); end
    check("R6 busy length", 32'(c), 32'(WC));
    rd(2 * PG + 9, 0, "R9 below range");
    for (int i = 0; i < 5; i++) rd(2 * PG + 10 + i, 8'hA0 + i, "R9 written");
    rd(2 * PG + 15, 0, "R9 above range");

    // R2: offset wraps, page fixed
    start(2 * PG + 62);
    for (int i = 0; i < 4; i++) send(8'hB0 + i, 1);
    check("R2 page kept", 32'(grant_addr_o), 32'(2 * PG + 2));
    csr(0);
    wait_idle();
    rd(2 * PG + 62, 8'hB0, "R2 slot 62");
    rd(2 * PG + 63, 8'hB1, "R2 slot 63");
    rd(2 * PG + 0, 8'hB2, "R2 slot 0");
    rd(2 * PG + 1, 8'hB3, "R2 slot 1");
    rd(3 * PG + 0, 0, "R2 next page untouched");

    // R3: 70 bytes overwrite first six
    start(3 * PG);
    for (int i = 0; i < 70; i++) send(i, 1);
    csr(0);
    wait_idle();
    rd(3 * PG + 0, 64, "R3 overwritten 0");
    rd(3 * PG + 5, 69, "R3 overwritten 5");
    rd(3 * PG + 6, 6, "R3 kept 6");
    rd(3 * PG + 63, 63, "R3 kept 63");

    // R4: release off a byte boundary, with no bytes, and with no write open
    start(4 * PG);
    send(8'hC0, 1);
    csr(3);
    check("R4 mid-byte no busy", 32'(busy_o), 0);
    rd(4 * PG, 0, "R4 array unchanged");
    start(4 * PG);
    csr(0);
    check("R4 empty no busy", 32'(busy_o), 0);
    send(8'hC1, 1);
    csr(0);
    check("R4 no open write", 32'(busy_o), 0);

    // R5: latch clear
    wel = 0;
    start(4 * PG + 1);
    send(8'hD0, 1);
    csr(0);
    check("R5 no busy", 32'(busy_o), 0);
    rd(4 * PG + 1, 0, "R5 array unchanged");
    wel = 1;

    // R8: denied bytes skipped
    start(5 * PG);
    for (int i = 0; i < 4; i++) send(8'hE0 + i, (i % 2) == 0);
    csr(0);
    wait_idle();
    rd(5 * PG + 0, 8'hE0, "R8 granted 0");
    rd(5 * PG + 1, 0, "R8 denied 1");
    rd(5 * PG + 2, 8'hE2, "R8 granted 2");
    rd(5 * PG + 3, 0, "R8 denied 3");

    // R10 / R11: traffic during busy ignored
    rd(5 * PG + 2, 8'hE2, "R11 read");
    start(6 * PG);
    send(8'hF0, 1);
    csr(0);
    check("R10 busy started", 32'(busy_o), 1);
    start(7 * PG);
    send(8'h11, 1);
    csr(0);
    rd(5 * PG, 8'hE2, "R10 read held");
    c = 0;
    while (busy_o) begin c++; tick(); end
    check("R10 busy not extended", 32'(c), 32'(WC - 4));
    rd(7 * PG, 0, "R10 ignored write");
    rd(6 * PG, 8'hF0, "R11 committed byte");

    repeat (3) tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule